// File: doc/BRIEF.md
# Interrupt Status Bank with Read Acknowledge

This block gathers sixteen raw event lines into two 8-bit status registers, A and B. It drives one active-low interrupt line from them. Each status bit is fixed at build time as edge-set or level-set. An edge-set bit latches on a rising edge of its event and holds after the event drops. A level-set bit follows its event while the event is high. Each register has an 8-bit mask that the host writes, and an 8-bit acknowledge register that the block maintains by itself. When the host reads a status register, every bit that was 1 in the returned value becomes acknowledged, and an acknowledged bit no longer drives the interrupt line. Events are captured whatever the mask says. Every event line passes through a two-flop synchronizer before it is sampled.

Each status bit is a small state machine with three states. `CELL_IDLE` means the status bit is 0. `CELL_PEND` means the status bit is 1 and not acknowledged. `CELL_ACKD` means the status bit is 1 and acknowledged. The transitions are:
- `set` takes `CELL_IDLE` to `CELL_PEND`, on a rising edge for an edge-set bit or on a high level for a level-set bit.
- `ack` takes `CELL_PEND` to `CELL_ACKD` when the host reads the register.
- `drop` takes a level-set bit from `CELL_PEND` to `CELL_IDLE` when its event is low.
- `release` takes any bit from `CELL_ACKD` to `CELL_IDLE` when its event is low.

Top module: `irq_status_bank`

## Requirements
- R1: Status bits A5, A0, B7, B6 and B5 are edge-set. Each one becomes 1 on a rising edge of its event and stays 1 after the event returns low, until it is acknowledged.
- R2: Status bits A7, A6, A4..A1 and B3..B0 are level-set. Each one is 1 while its synchronized event is high, and it returns to 0 when the event is low, whether or not it was acknowledged.
- R3: A read is requested with `rd_en` high and `addr` set at a clock edge. The result appears on `rd_data` after that edge and holds until the next read. The address map is: 0 status A, 1 status B, 2 mask A, 3 mask B, 4 acknowledge A, 5 acknowledge B, 6 and 7 read as 0. The value returned is the register content just before that edge. Reading address 0 or 1 sets the acknowledge bit of every status bit that was 1 in the returned value.
- R4: An edge-set bit clears only when its acknowledge bit is set and its event is low. When it clears, its acknowledge bit clears with it.
- R5: An acknowledge bit is 1 only while its status bit is 1, and it clears in the same edge as its status bit.
- R6: `irq_n` is low exactly when some status bit is 1 while both its mask bit and its acknowledge bit are 0.
- R7: Events are captured even when masked. Clearing the mask bit of a pending, unacknowledged status bit drives `irq_n` low right after the write edge.
- R8: A status bit that becomes 1 at the same edge as a read of its register reads back as 0 in that read. It is not acknowledged by that read, and it stays pending.
- R9: Status bit B4 has no event behind it and always reads 0. `evt_b[4]` never affects `irq_n`.
- R10: Writing with `wr_en` high loads `wr_data` into mask A (address 2) or mask B (address 3). A write to any other address changes nothing.
- R11: After reset, every status and acknowledge bit is 0, both masks are 0xFF, `rd_data` is 0 and `irq_n` is high.
- R12: An event level present at clock edge k is reflected in the status register after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_a | input | 8 | Raw event lines for status register A |
| evt_b | input | 8 | Raw event lines for status register B |
| rd_en | input | 1 | Read request for the register at `addr` |
| wr_en | input | 1 | Write request for the register at `addr` |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 8 | Write data for the mask registers |
| rd_data | output | 8 | Registered read result |
| irq_n | output | 1 | Active-low combined interrupt |

## Verification
The checker watches every cycle for four things:
- an acknowledge bit that appears without a read of its status register;
- an edge-set bit that falls without having been acknowledged;
- a bit that is acknowledged in the same edge in which it first becomes 1;
- mask writes that do not take effect, and a low `irq_n` while every status bit is 0.

Some behaviours depend on the event history. These are the two-edge capture latency, the level bits clearing without a read, the same-edge collision between a read and a new event, and the interrupt appearing when a mask is lifted. Only the bench's scenarios can show them. The bench compares `irq_n` and `rd_data` after every edge against a model built from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned SYNC_DEPTH = 2;

    // Build-time bit personalities: 1 = edge-set, 0 = level-set
    localparam logic [REG_W-1:0] EDGE_A_DEF = 8'b0010_0001;
    localparam logic [REG_W-1:0] EDGE_B_DEF = 8'b1110_0000;
    // 1 = bit has an event behind it, 0 = tied to zero
    localparam logic [REG_W-1:0] LIVE_A_DEF = 8'hFF;
    localparam logic [REG_W-1:0] LIVE_B_DEF = 8'hEF;

    localparam logic [ADDR_W-1:0] ADR_STAT_A = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK_A = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MASK_B = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ACK_A  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_ACK_B  = 3'd5;

    typedef enum logic [1:0] {
        CELL_IDLE = 2'd0,
        CELL_PEND = 2'd1,
        CELL_ACKD = 2'd2
    } cell_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] now_q,
    output logic [W-1:0] prev_q
);
    localparam int unsigned TAPS = DEPTH + 1;

    logic [W-1:0] pipe [TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < TAPS; j++) pipe[j] <= '0;
        end else begin
            pipe[0] <= din;
            for (int j = 1; j < TAPS; j++) pipe[j] <= pipe[j-1];
        end
    end

    assign now_q  = pipe[DEPTH-1];
    assign prev_q = pipe[DEPTH];
endmodule

// File: rtl/irq_bit_cell.sv
module irq_bit_cell
    import irq_pkg::*;
#(
    parameter bit EDGE_SET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic ack_hit,
    output logic status,
    output logic acked
);
    cell_state_e state_q, state_d;
    logic        trigger;

    assign trigger = EDGE_SET ? (lvl & ~lvl_prev) : lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CELL_IDLE;
        else        state_q <= state_d;
    end

    // transitions: set, ack, drop, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: if (trigger) state_d = CELL_PEND;
            CELL_PEND: begin
                if (!EDGE_SET && !lvl) state_d = CELL_IDLE;
                else if (ack_hit)      state_d = CELL_ACKD;
            end
            CELL_ACKD: if (!lvl) state_d = CELL_IDLE;
            default:   state_d = CELL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        status = (state_q != CELL_IDLE);
        acked  = (state_q == CELL_ACKD);
    end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_pkg::*;
#(
    parameter int unsigned     W         = REG_W,
    parameter logic [W-1:0]    EDGE_MASK = '0,
    parameter logic [W-1:0]    LIVE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic         rd_hit,
    output logic [W-1:0] status,
    output logic [W-1:0] acked
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE_MASK[i]) begin : g_live
            irq_bit_cell #(
                .EDGE_SET (EDGE_MASK[i])
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl      (lvl[i]),
                .lvl_prev (lvl_prev[i]),
                .ack_hit  (rd_hit & status[i]),
                .status   (status[i]),
                .acked    (acked[i])
            );
        end else begin : g_tied
            logic unused_in;
            assign unused_in = lvl[i] ^ lvl_prev[i];
            assign status[i] = 1'b0;
            assign acked[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_pkg::*;
#(
    parameter int unsigned  W      = REG_W,
    parameter logic [W-1:0] EDGE_A = EDGE_A_DEF,
    parameter logic [W-1:0] EDGE_B = EDGE_B_DEF,
    parameter logic [W-1:0] LIVE_A = LIVE_A_DEF,
    parameter logic [W-1:0] LIVE_B = LIVE_B_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      evt_a,
    input  logic [W-1:0]      evt_b,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    output logic              irq_n
);
    localparam int unsigned NB = 2 * W;

    logic [NB-1:0] lvl_now, lvl_old;
    logic [W-1:0]  stat_a, stat_b, ack_a, ack_b;
    logic [W-1:0]  mask_a, mask_b;
    logic          rd_stat_a, rd_stat_b;

    irq_sync #(
        .W     (NB),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({evt_b, evt_a}),
        .now_q  (lvl_now),
        .prev_q (lvl_old)
    );

    assign rd_stat_a = rd_en && (addr == ADR_STAT_A);
    assign rd_stat_b = rd_en && (addr == ADR_STAT_B);

    irq_reg_bank #(
        .W         (W),
        .EDGE_MASK (EDGE_A),
        .LIVE_MASK (LIVE_A)
    ) u_bank_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_now[W-1:0]),
        .lvl_prev (lvl_old[W-1:0]),
        .rd_hit   (rd_stat_a),
        .status   (stat_a),
        .acked    (ack_a)
    );

    irq_reg_bank #(
        .W         (W),
        .EDGE_MASK (EDGE_B),
        .LIVE_MASK (LIVE_B)
    ) u_bank_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_now[NB-1:W]),
        .lvl_prev (lvl_old[NB-1:W]),
        .rd_hit   (rd_stat_b),
        .status   (stat_b),
        .acked    (ack_b)
    );

    // host mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_a <= '1;
            mask_b <= '1;
        end else if (wr_en) begin
            if (addr == ADR_MASK_A) mask_a <= wr_data;
            if (addr == ADR_MASK_B) mask_b <= wr_data;
        end
    end

    // read snapshot: captures content before this edge's updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (addr)
                ADR_STAT_A: rd_data <= stat_a;
                ADR_STAT_B: rd_data <= stat_b;
                ADR_MASK_A: rd_data <= mask_a;
                ADR_MASK_B: rd_data <= mask_b;
                ADR_ACK_A:  rd_data <= ack_a;
                ADR_ACK_B:  rd_data <= ack_b;
                default:    rd_data <= '0;
            endcase
        end
    end

    assign irq_n = ~(|(stat_a & ~mask_a & ~ack_a) | |(stat_b & ~mask_b & ~ack_b));
endmodule

// File: rtl/irq_status_checks.sv
module irq_status_checks
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_n,
    input logic [REG_W-1:0]  stat_a,
    input logic [REG_W-1:0]  stat_b,
    input logic [REG_W-1:0]  ack_a,
    input logic [REG_W-1:0]  ack_b,
    input logic [REG_W-1:0]  mask_a,
    input logic [REG_W-1:0]  mask_b
);
    // R3: acknowledge bits appear only after a read of their status register
    a_r3_ack_needs_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_a & ~$past(ack_a))) |-> $past(rd_en && addr == ADR_STAT_A));
    a_r3_ack_needs_read_b: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_b & ~$past(ack_b))) |-> $past(rd_en && addr == ADR_STAT_B));

    // R3: mask readback returns the value held before the read edge
    a_r3_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_MASK_A) |=> (rd_data == $past(mask_a)));

    // R4: an edge-set bit never falls without having been acknowledged
    a_r4_edge_needs_ack_a: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_a) & ~stat_a & EDGE_A_DEF & ~$past(ack_a)) == '0));
    a_r4_edge_needs_ack_b: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_b) & ~stat_b & EDGE_B_DEF & ~$past(ack_b)) == '0));

    // R6: interrupt low needs a pending status bit
    a_r6_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|stat_a || |stat_b));

    // R6: fully masked bank keeps the line high
    a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_a && &mask_b) |-> irq_n);

    // R8: a bit just set is never already acknowledged
    a_r8_new_not_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (((stat_a & ~$past(stat_a) & ack_a) == '0) &&
         ((stat_b & ~$past(stat_b) & ack_b) == '0)));

    // R9: bit 4 of status B never reads back as 1
    a_r9_b4_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_STAT_B) |=> !rd_data[4]);

    // R10: mask writes take effect at the write edge
    a_r10_mask_a_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_MASK_A) |=> (mask_a == $past(wr_data)));
    a_r10_mask_b_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_MASK_B) |=> (mask_b == $past(wr_data)));
endmodule

bind irq_status_bank irq_status_checks u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .stat_a  (stat_a),
    .stat_b  (stat_b),
    .ack_a   (ack_a),
    .ack_b   (ack_b),
    .mask_a  (mask_a),
    .mask_b  (mask_b)
);

// File: tb/irq_status_bank_bench.sv
module irq_status_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_a = '0, evt_b = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    always #10 clk = ~clk;   // 50 MHz

    irq_status_bank u_irq_status_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_a   (evt_a),
        .evt_b   (evt_b),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_n   (irq_n)
    );

    // Requirement-level constants (R1, R2, R9)
    localparam bit [15:0] EDGE_BITS = {8'b1110_0000, 8'b0010_0001};
    localparam bit [15:0] LIVE_BITS = {8'hEF, 8'hFF};

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    // model state
    bit [15:0] m_s1, m_s2, m_s3;
    bit [1:0]  m_st [16];      // 0 clear, 1 pending, 2 acknowledged
    bit [7:0]  m_mka = 8'hFF, m_mkb = 8'hFF;
    bit [7:0]  m_rd = 8'h00;
    bit [7:0]  cur_a = '0, cur_b = '0;

    function automatic bit [15:0] m_stat();
        bit [15:0] v = '0;
        for (int i = 0; i < 16; i++) v[i] = (m_st[i] != 2'd0);
        return v;
    endfunction

    function automatic bit [15:0] m_ack();
        bit [15:0] v = '0;
        for (int i = 0; i < 16; i++) v[i] = (m_st[i] == 2'd2);
        return v;
    endfunction

    function automatic bit m_irq_n();
        return !(|(m_stat() & ~{m_mkb, m_mka} & ~m_ack()));
    endfunction

    function automatic bit [7:0] m_read(input bit [2:0] a);
        bit [15:0] s = m_stat();
        bit [15:0] k = m_ack();
        case (a)
            3'd0: return s[7:0];
            3'd1: return s[15:8];
            3'd2: return m_mka;
            3'd3: return m_mkb;
            3'd4: return k[7:0];
            3'd5: return k[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic step(input bit rd, input bit wr, input bit [2:0] a,
                        input bit [7:0] wd, input string tag);
        bit [1:0] nst [16];
        bit [15:0] s;
        evt_a = cur_a; evt_b = cur_b;
        rd_en = rd; wr_en = wr; addr = a; wr_data = wd;
        if (rd) m_rd = m_read(a);
        s = m_stat();
        for (int i = 0; i < 16; i++) begin
            bit lv, pv, hit, trig;
            nst[i] = m_st[i];
            lv   = m_s2[i];
            pv   = m_s3[i];
            hit  = rd && s[i] && ((i < 8) ? (a == 3'd0) : (a == 3'd1));
            trig = EDGE_BITS[i] ? (lv && !pv) : lv;
            if (!LIVE_BITS[i]) nst[i] = 2'd0;
            else case (m_st[i])
                2'd0: if (trig) nst[i] = 2'd1;
                2'd1: if (!EDGE_BITS[i] && !lv) nst[i] = 2'd0;
                      else if (hit) nst[i] = 2'd2;
                default: if (!lv) nst[i] = 2'd0;
            endcase
        end
        for (int i = 0; i < 16; i++) m_st[i] = nst[i];
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = {cur_b, cur_a};
        if (wr && a == 3'd2) m_mka = wd;
        if (wr && a == 3'd3) m_mkb = wd;
        @(negedge clk);
        chk({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, m_irq_n()});
        chk({tag, " rd_data"}, rd_data, m_rd);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00, tag);
    endtask

    task automatic rd(input bit [2:0] a, input string tag);
        step(1'b1, 1'b0, a, 8'h00, tag);
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d, input string tag);
        step(1'b0, 1'b1, a, d, tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_st[i] = 2'd0;
        m_s1 = '0; m_s2 = '0; m_s3 = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11 rd_data reset", rd_data, 8'h00);
        chk("R11 irq_n reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R10 / R3: reset values, mask access, unused addresses
        rd(3'd2, "R11"); chk("R11 mask A reset", rd_data, 8'hFF);
        rd(3'd3, "R11"); chk("R11 mask B reset", rd_data, 8'hFF);
        rd(3'd6, "R3");  chk("R3 unused address", rd_data, 8'h00);
        wr(3'd2, 8'h00, "R10");
        wr(3'd0, 8'hFF, "R10");
        rd(3'd0, "R10"); chk("R10 write to status ignored", rd_data, 8'h00);
        rd(3'd2, "R10"); chk("R10 mask A readback", rd_data, 8'h00);

        // R12 / R3 / R4 / R5: edge bit A0 pulse, read, release
        cur_a = 8'h01; idle(1, "R12");
        cur_a = 8'h00; idle(1, "R12");
        chk("R12 not yet visible", {7'b0, irq_n}, 8'h01);
        idle(1, "R12");
        chk("R12 visible after k+2", {7'b0, irq_n}, 8'h00);
        rd(3'd0, "R3"); chk("R3 status snapshot", rd_data, 8'h01);
        chk("R3 ack hides irq", {7'b0, irq_n}, 8'h01);
        rd(3'd4, "R3"); chk("R3 ack register", rd_data, 8'h01);
        rd(3'd0, "R4"); chk("R4 released after ack and low", rd_data, 8'h00);
        rd(3'd4, "R5"); chk("R5 ack cleared with status", rd_data, 8'h00);

        // R1: edge bit A5 kept after its event drops
        cur_a = 8'h20; idle(1, "R1");
        cur_a = 8'h00; idle(5, "R1");
        rd(3'd0, "R1"); chk("R1 edge bit held", rd_data, 8'h20);
        idle(1, "R4");
        rd(3'd0, "R4"); chk("R4 edge bit cleared", rd_data, 8'h00);

        // R4: edge bit stays while event high even when acknowledged
        cur_a = 8'h20; idle(3, "R4");
        rd(3'd0, "R4"); chk("R4 first read", rd_data, 8'h20);
        idle(3, "R4");
        rd(3'd0, "R4"); chk("R4 held while high", rd_data, 8'h20);
        rd(3'd4, "R4"); chk("R4 ack held", rd_data, 8'h20);
        cur_a = 8'h00; idle(4, "R4");
        rd(3'd0, "R4"); chk("R4 cleared after drop", rd_data, 8'h00);

        // R2: level bit A1 follows its event without a read
        cur_a = 8'h02; idle(3, "R2");
        chk("R2 level raises irq", {7'b0, irq_n}, 8'h00);
        cur_a = 8'h00; idle(3, "R2");
        chk("R2 level clears irq", {7'b0, irq_n}, 8'h01);
        rd(3'd0, "R2"); chk("R2 level status cleared", rd_data, 8'h00);

        // R7: masked capture, then unmask
        wr(3'd2, 8'hFF, "R7");
        cur_a = 8'h04; idle(3, "R7");
        chk("R7 masked quiet", {7'b0, irq_n}, 8'h01);
        wr(3'd2, 8'h00, "R7");
        chk("R7 unmask raises irq", {7'b0, irq_n}, 8'h00);
        cur_a = 8'h00; idle(3, "R7");

        // R8: read on the edge where the bit becomes set
        cur_a = 8'h08; idle(2, "R8");
        rd(3'd0, "R8"); chk("R8 collision read", rd_data, 8'h00);
        chk("R8 still pending", {7'b0, irq_n}, 8'h00);
        rd(3'd0, "R8"); chk("R8 visible next read", rd_data, 8'h08);
        cur_a = 8'h00; idle(3, "R8");

        // R9 and R1 on register B
        wr(3'd3, 8'h00, "R9");
        cur_b = 8'h10; idle(4, "R9");
        chk("R9 unused bit silent", {7'b0, irq_n}, 8'h01);
        rd(3'd1, "R9"); chk("R9 B4 reads zero", rd_data, 8'h00);
        cur_b = 8'h80; idle(1, "R1");
        cur_b = 8'h00; idle(4, "R1");
        rd(3'd1, "R1"); chk("R1 B7 edge held", rd_data, 8'h80);
        chk("R1 B7 acked", {7'b0, irq_n}, 8'h01);
        idle(2, "R1");

        // random traffic against the model (R3, R6)
        for (int n = 0; n < 4000; n++) begin
            bit rsel, wsel;
            if ($urandom % 6 == 0) cur_a ^= 8'(1 << ($urandom % 8));
            if ($urandom % 6 == 0) cur_b ^= 8'(1 << ($urandom % 8));
            rsel = ($urandom % 3 == 0);
            wsel = !rsel && ($urandom % 20 == 0);
            step(rsel, wsel, 3'($urandom % 8), 8'($urandom), "R6 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL all watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule